// File: doc/BRIEF.md
# Oversampling Accumulator with Shifter

This block sits behind a converter and turns a burst of consecutive 12-bit conversion results into one averaged data word. Each result arrives with a one-cycle valid strobe. While oversampling is switched on, the block sums a programmable number of results (a power of two from 2 up to 256) into a 20-bit accumulator. When the last result of the burst arrives, it shifts the sum right by a programmable amount and keeps the low 16 bits as the output word, with a single end-of-conversion strobe.

When oversampling is switched off, every input result goes straight to the output, zero-extended to 16 bits, and each one gives its own strobe. Switching oversampling off also throws away any partly collected burst, so the next burst after it is enabled again starts from an empty sum.

Top module: `ovs_accum`

## Requirements
- R1: While reset is held and right after it, `result` is 0 and `result_stb` is 0.
- R2: With oversampling on, a burst holds 2^(n+1) accepted samples, where n is the 3-bit `ratio_sel` value (0 gives 2, 7 gives 256). `result_stb` is raised only for the last sample of a burst.
- R3: The sum of a burst is kept exactly in 20 bits. A full 256-sample burst of 4095 gives 0xFFF00 with no loss.
- R4: The output word is the burst sum shifted right by `shift_sel` bits (0 to 8), reduced to its low 16 bits.
- R5: Any `shift_sel` value from 9 to 15 acts as a shift of 8.
- R6: `result_stb` is a one-cycle pulse in the cycle after the clock edge that takes the final sample. `result` changes only in that cycle and holds its value at all other times.
- R7: With oversampling off, each accepted sample appears on `result` with bits 15:12 set to zero, and `result_stb` pulses in the cycle after that sample's clock edge.
- R8: Turning oversampling off clears the partial sum and the sample count. After it is turned on again, a burst holds exactly the full 2^(n+1) new samples.
- R9: Cycles with `sample_vld` low do not add to the sum and do not advance the count, whatever `sample_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_enable | input | 1 | 1: oversampling on; 0: pass-through |
| ratio_sel | input | 3 | Burst length code n, giving 2^(n+1) samples |
| shift_sel | input | 4 | Right shift applied to the burst sum, 0 to 8 |
| sample_vld | input | 1 | Strobe that marks a new conversion result |
| sample_data | input | 12 | Conversion result |
| result | output | 16 | Averaged or passed-through data word |
| result_stb | output | 1 | End-of-conversion pulse for `result` |

## Verification
Every result is due exactly one cycle after the rising edge that accepts the sample that completes it. This holds for the final sample of a burst and for every sample in pass-through. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, half a cycle after the edge that registers them. It also checks the strobe low after each non-final sample and one cycle after each pulse, so an early, late or stretched strobe is caught. Idle cycles carrying junk data are placed inside bursts, and bursts are cut short by disabling, so that the expected sums show whether anything was wrongly counted.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int IN_W      = 12;
  localparam int ACC_W     = 20;
  localparam int OUT_W     = 16;
  localparam int RATIO_W   = 3;
  localparam int SHIFT_W   = 4;
  localparam int MAX_SHIFT = 8;
  // largest burst is 2**(2**RATIO_W); counter spans that minus one
  localparam int CNT_W     = 2 ** RATIO_W;
endpackage

// File: rtl/ovs_counter.sv
module ovs_counter #(
  parameter int RATIO_W = ovs_pkg::RATIO_W,
  parameter int CNT_W   = ovs_pkg::CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               step,
  input  logic [RATIO_W-1:0] ratio_sel,
  output logic               burst_last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             cnt_ce;

  // limit = 2**(n+1) - 1; wraps to all ones for the deepest code
  assign limit      = (CNT_W'(1) << ({1'b0, ratio_sel} + (RATIO_W+1)'(1))) - CNT_W'(1);
  assign burst_last = enable && step && (cnt_q == limit);
  assign cnt_ce     = !enable || step;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable || burst_last) cnt_d = '0;
    else if (step)             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R2: the count never passes the burst limit while the ratio is held
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ratio_sel) |-> (cnt_q <= limit));
  // R8: disabling empties the count
  assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));
endmodule

// File: rtl/ovs_adder.sv
module ovs_adder #(
  parameter int IN_W  = ovs_pkg::IN_W,
  parameter int ACC_W = ovs_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step,
  input  logic             burst_last,
  input  logic [IN_W-1:0]  sample,
  output logic [ACC_W-1:0] sum_now
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_ce;

  assign sum_now = acc_q + ACC_W'(sample);
  assign acc_ce  = !enable || step;

  always_comb begin
    acc_d = acc_q;
    if (!enable || burst_last) acc_d = '0;
    else if (step)             acc_d = sum_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  // R3: inside a burst the sum only grows; a wrap would show as a drop
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step && !burst_last) |=> (acc_q >= $past(acc_q)));
  // R9: without a valid sample the sum is left alone
  assert_idle_holds_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !step) |=> $stable(acc_q));
  // R8: disabling empties the sum
  assert_sum_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (acc_q == '0));
endmodule

// File: rtl/ovs_shifter.sv
module ovs_shifter #(
  parameter int ACC_W     = ovs_pkg::ACC_W,
  parameter int OUT_W     = ovs_pkg::OUT_W,
  parameter int SHIFT_W   = ovs_pkg::SHIFT_W,
  parameter int MAX_SHIFT = ovs_pkg::MAX_SHIFT
) (
  input  logic [ACC_W-1:0]   sum_in,
  input  logic [SHIFT_W-1:0] shift_sel,
  output logic [OUT_W-1:0]   word_out
);
  logic [OUT_W-1:0]   cand [MAX_SHIFT+1];
  logic [SHIFT_W-1:0] sel_clamped;

  for (genvar g = 0; g <= MAX_SHIFT; g++) begin : g_tap
    logic [ACC_W-1:0] shifted;
    assign shifted = sum_in >> g;
    assign cand[g] = shifted[OUT_W-1:0];
  end

  assign sel_clamped = (shift_sel > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : shift_sel;

  always_comb begin
    word_out = cand[0];
    for (int i = 1; i <= MAX_SHIFT; i++)
      if (sel_clamped == SHIFT_W'(i)) word_out = cand[i];
  end

  // R5: the clamped shift never leaves the supported range
  always_comb assert_shift_clamped_R5: assert (sel_clamped <= SHIFT_W'(MAX_SHIFT));
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
#(
  parameter int P_IN_W      = IN_W,
  parameter int P_ACC_W     = ACC_W,
  parameter int P_OUT_W     = OUT_W,
  parameter int P_RATIO_W   = RATIO_W,
  parameter int P_SHIFT_W   = SHIFT_W,
  parameter int P_MAX_SHIFT = MAX_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_enable,
  input  logic [P_RATIO_W-1:0] ratio_sel,
  input  logic [P_SHIFT_W-1:0] shift_sel,
  input  logic                 sample_vld,
  input  logic [P_IN_W-1:0]    sample_data,
  output logic [P_OUT_W-1:0]   result,
  output logic                 result_stb
);
  localparam int P_CNT_W = 2 ** P_RATIO_W;

  logic               burst_last;
  logic [P_ACC_W-1:0] sum_now;
  logic [P_OUT_W-1:0] avg_word;
  logic [P_OUT_W-1:0] res_d;
  logic               stb_d;
  logic               res_ce;

  ovs_counter #(.RATIO_W(P_RATIO_W), .CNT_W(P_CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(os_enable), .step(sample_vld),
    .ratio_sel(ratio_sel), .burst_last(burst_last));

  ovs_adder #(.IN_W(P_IN_W), .ACC_W(P_ACC_W)) u_add (
    .clk(clk), .rst_n(rst_n), .enable(os_enable), .step(sample_vld),
    .burst_last(burst_last), .sample(sample_data), .sum_now(sum_now));

  ovs_shifter #(.ACC_W(P_ACC_W), .OUT_W(P_OUT_W), .SHIFT_W(P_SHIFT_W),
                .MAX_SHIFT(P_MAX_SHIFT)) u_shf (
    .sum_in(sum_now), .shift_sel(shift_sel), .word_out(avg_word));

  always_comb begin
    stb_d  = os_enable ? burst_last : sample_vld;
    res_ce = stb_d;
    res_d  = os_enable ? avg_word : P_OUT_W'(sample_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      result_stb <= 1'b0;
    end else begin
      result_stb <= stb_d;
      if (res_ce) result <= res_d;
    end
  end

  // R6: a strobe always follows an accepted sample
  assert_stb_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_stb |-> $past(sample_vld));
  // R6: the output word only moves together with the strobe
  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !result_stb |-> $stable(result));
  // R7: pass-through delivers the zero-extended sample one cycle later
  assert_pass_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_enable && sample_vld) |=> (result_stb && result == P_OUT_W'($past(sample_data))));
endmodule

// File: tb/tb_ovs_accum.sv
module tb_ovs_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        os_enable = 1'b0;
  logic [2:0]  ratio_sel = '0;
  logic [3:0]  shift_sel = '0;
  logic        sample_vld = 1'b0;
  logic [11:0] sample_data = '0;
  logic [15:0] result;
  logic        result_stb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ovs_accum dut (
    .clk(clk), .rst_n(rst_n), .os_enable(os_enable), .ratio_sel(ratio_sel),
    .shift_sel(shift_sel), .sample_vld(sample_vld), .sample_data(sample_data),
    .result(result), .result_stb(result_stb));

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  // drive one sample, return at the falling edge after it was taken
  task automatic push(input logic [11:0] d);
    @(negedge clk);
    sample_vld  = 1'b1;
    sample_data = d;
    @(negedge clk);
    sample_vld  = 1'b0;
    sample_data = 12'hA5A;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_data = 12'hFFF;
    end
  endtask

  // one burst of constant or ramp data; checks strobe placement and word
  task automatic burst(input string req, input logic [2:0] code, input logic [3:0] sh,
                       input int base, input int step_v, input bit gaps);
    int n = 1 << (code + 1);
    int sum = 0;
    int eff = (sh > 8) ? 8 : sh;
    int mid_stb = 0;
    ratio_sel = code;
    shift_sel = sh;
    os_enable = 1'b1;
    for (int i = 0; i < n; i++) begin
      int v = (base + i * step_v) & 12'hFFF;
      sum += v;
      push(v[11:0]);
      if (i < n - 1) begin
        mid_stb |= result_stb;
        if (gaps) idle(1);
      end
    end
    chk("R2", "strobe before last sample", mid_stb, 0);
    chk(req, "strobe at burst end", result_stb, 1);
    chk(req, "burst word", result, (sum >> eff) & 16'hFFFF);
    idle(1);
    chk("R6", "strobe is one cycle", result_stb, 0);
    chk("R6", "word held", result, (sum >> eff) & 16'hFFFF);
  endtask

  task automatic t_reset();
    chk("R1", "reset result", result, 0);
    chk("R1", "reset strobe", result_stb, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "result after reset", result, 0);
    chk("R1", "strobe after reset", result_stb, 0);
  endtask

  task automatic t_pass();
    os_enable = 1'b0;
    shift_sel = 4'd3;
    push(12'hABC);
    chk("R7", "pass strobe", result_stb, 1);
    chk("R7", "pass word", result, 16'h0ABC);
    push(12'hFFF);
    chk("R7", "pass word max", result, 16'h0FFF);
    idle(1);
    chk("R7", "no strobe without sample", result_stb, 0);
  endtask

  task automatic t_back_to_back();
    ratio_sel = 3'd0;
    shift_sel = 4'd0;
    os_enable = 1'b1;
    @(negedge clk); sample_vld = 1'b1; sample_data = 12'd10;
    @(negedge clk); chk("R2", "b2b first", result_stb, 0); sample_data = 12'd20;
    @(negedge clk); chk("R2", "b2b burst1 strobe", result_stb, 1);
                    chk("R4", "b2b burst1 word", result, 30); sample_data = 12'd40;
    @(negedge clk); chk("R6", "b2b between", result_stb, 0); sample_data = 12'd50;
    @(negedge clk); chk("R2", "b2b burst2 strobe", result_stb, 1);
                    chk("R4", "b2b burst2 word", result, 90);
    sample_vld = 1'b0;
    idle(1);
  endtask

  task automatic t_disable_clears();
    ratio_sel = 3'd1;
    shift_sel = 4'd0;
    os_enable = 1'b1;
    push(12'd700);
    push(12'd800);
    chk("R8", "partial burst no strobe", result_stb, 0);
    @(negedge clk); os_enable = 1'b0;
    @(negedge clk); os_enable = 1'b1;
    chk("R8", "disable without sample gives no strobe", result_stb, 0);
    push(12'd1); chk("R8", "fresh 1", result_stb, 0);
    push(12'd2); chk("R8", "fresh 2", result_stb, 0);
    push(12'd3); chk("R8", "fresh 3", result_stb, 0);
    push(12'd4);
    chk("R8", "fresh burst strobe", result_stb, 1);
    chk("R8", "fresh burst word", result, 10);
    idle(1);
  endtask

  initial begin
    t_reset();
    t_pass();
    burst("R2", 3'd0, 4'd0, 100, 100, 1'b0);   // x2: 100+200
    burst("R9", 3'd2, 4'd1, 5, 300, 1'b1);     // x8 with idle junk cycles
    burst("R4", 3'd3, 4'd4, 5, 37, 1'b0);      // x16 ramp, shift 4
    burst("R3", 3'd7, 4'd8, 4095, 0, 1'b0);    // x256 full scale -> 0x0FFF
    burst("R4", 3'd7, 4'd0, 4095, 0, 1'b0);    // low 16 of 0xFFF00 -> 0xFF00
    burst("R4", 3'd7, 4'd2, 4095, 0, 1'b0);    // 0x3FFC0 -> 0xFFC0
    burst("R5", 3'd7, 4'd12, 4095, 0, 1'b0);   // clamp to 8 -> 0x0FFF
    burst("R5", 3'd4, 4'd15, 4000, 3, 1'b1);   // x32, clamp to 8
    t_back_to_back();
    t_disable_clears();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule